// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block carries out the reset-time start-up of a processor core. It tells a cold (power-on) reset apart from a warm (manual) reset. Once reset is released it makes two 32-bit reads over a simple request/acknowledge memory port. The first read returns the initial program counter. The second returns the initial stack pointer. The vector pair sits at a different base address for each reset kind.

While reset is held, the block loads fixed start-up values into the architectural state it owns:
- the vector base register,
- the interrupt mask field,
- two status flags,
- the interrupt-bank select bit,
- the floating-point control/status word. Only a cold reset loads this word; a warm reset keeps its earlier value.

When both reads have finished, a run-enable output tells the core that it may begin executing at the fetched program counter. Asserting either reset at any point abandons the sequence, and it begins again from the first read. If both resets are active, the cold reset wins.

Top module: `boot_vec_seq`

## Requirements
- R1: After a cold reset, the first read goes to address 0x00000000 and loads the program counter. The second read goes to address 0x00000004 and loads the stack pointer.
- R2: After a warm reset, the first read goes to address 0x00000008 and the second read goes to address 0x0000000C.
- R3: The stack-pointer read starts only after the program-counter read has been acknowledged. A request stays asserted, with a stable address, for as many cycles as the acknowledge takes; there is no timeout.
- R4: While any reset is sampled active, the block loads these values: vector base 0x00000000, interrupt mask 4'hF, both status flags 0, bank-select bit 0.
- R5: A cold reset loads the floating-point control word with 0x00040001. A warm reset leaves it unchanged.
- R6: `pcOut` holds the data returned by the first read, and `spOut` holds the data returned by the second read.
- R7: `runEn` is low during reset and during both reads. It goes high on the clock edge after the edge that samples the stack-pointer acknowledge, and it stays high until the next reset.
- R8: A reset asserted during the sequence aborts it. After release, the next request is again the program-counter read at the base address of the new reset kind.
- R9: When both resets are active together, the block behaves as for a cold reset: it uses base address 0x00000000 and loads the floating-point control word.
- R10: `memReq` is low while any reset is active and while `runEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst | input | 1 | Cold (power-on) reset, active high, sampled synchronously |
| manRst | input | 1 | Warm (manual) reset, active high, sampled synchronously |
| memReq | output | 1 | Read request, held until acknowledged |
| memAddr | output | 32 | Read address |
| memAck | input | 1 | Read acknowledge, one-cycle pulse, qualifies memRdata |
| memRdata | input | 32 | Read data |
| pcOut | output | 32 | Initial program counter |
| spOut | output | 32 | Initial stack pointer |
| vbrOut | output | 32 | Vector base register |
| intMask | output | 4 | Interrupt mask field |
| boBit | output | 1 | Status flag, cleared on reset |
| csBit | output | 1 | Status flag, cleared on reset |
| bankBit | output | 1 | Interrupt-bank select bit, cleared on reset |
| fpscrOut | output | 32 | Floating-point control/status word |
| runEn | output | 1 | Execution may start at pcOut |

## Verification
A wrong phase in the sequencer shows on the memory port within one cycle of reset release or of an acknowledge: the request goes to the wrong vector address, or the request is missing or duplicated. A wrongly latched reset kind shows the same way, and it also shows as a floating-point word that changes or stays fixed when it should not. Swapped or missed captures show in `pcOut` and `spOut` once `runEn` rises, which is one cycle after the last acknowledge. The bench sweeps every reset kind against several memory latencies, and then aborts the sequence in each wait phase.

// File: rtl/boot_vec_pkg.sv
package boot_vec_pkg;

  // sequencer phase
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_PC   = 2'd1,
    ST_SP   = 2'd2,
    ST_RUN  = 2'd3
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadInit;  // a reset is sampled active this cycle
    logic markPor;   // that reset includes the cold reset
    logic selSp;     // address the stack-pointer slot
    logic capPc;     // capture read data as program counter
    logic capSp;     // capture read data as stack pointer
  } seqStrobe_t;

endpackage

// File: rtl/boot_vec_ctrl.sv
module boot_vec_ctrl
  import boot_vec_pkg::*;
(
  input  logic       clk,
  input  logic       porRst,
  input  logic       manRst,
  input  logic       memAck,
  output seqStrobe_t strobe,
  output logic       memReq,
  output logic       runEn
);

  seqState_t state, stateNxt;
  logic      rstAny;

  assign rstAny = porRst | manRst;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_HOLD: stateNxt = ST_PC;
      ST_PC:   if (memAck) stateNxt = ST_SP;
      ST_SP:   if (memAck) stateNxt = ST_RUN;
      ST_RUN:  stateNxt = ST_RUN;
      default: stateNxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rstAny) state <= ST_HOLD;
    else        state <= stateNxt;
  end

  always_comb begin
    strobe          = '0;
    strobe.loadInit = rstAny;
    strobe.markPor  = porRst;
    strobe.selSp    = (state == ST_SP);
    strobe.capPc    = (state == ST_PC) && memAck && !rstAny;
    strobe.capSp    = (state == ST_SP) && memAck && !rstAny;
  end

  assign memReq = (state == ST_PC) || (state == ST_SP);
  assign runEn  = (state == ST_RUN);

endmodule

// File: rtl/boot_vec_dpath.sv
module boot_vec_dpath
  import boot_vec_pkg::*;
#(
  parameter int                ADDR_W        = 32,
  parameter int                DATA_W        = 32,
  parameter int                MASK_W        = 4,
  parameter logic [ADDR_W-1:0] POR_VEC_BASE  = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] MAN_VEC_BASE  = 32'h0000_0008,
  parameter logic [ADDR_W-1:0] SP_VEC_OFFSET = 32'h0000_0004,
  parameter logic [DATA_W-1:0] FPSCR_INIT    = 32'h0004_0001
) (
  input  logic              clk,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] vbrOut,
  output logic [MASK_W-1:0] intMask,
  output logic              boBit,
  output logic              csBit,
  output logic              bankBit,
  output logic [DATA_W-1:0] fpscrOut
);

  localparam logic [MASK_W-1:0] MASK_ALL = {MASK_W{1'b1}};

  logic              porKind;
  logic [ADDR_W-1:0] vecBase;

  // reset kind is latched while reset is active
  always_ff @(posedge clk) begin
    if (strobe.loadInit) porKind <= strobe.markPor;
  end

  assign vecBase = porKind ? POR_VEC_BASE : MAN_VEC_BASE;
  assign memAddr = vecBase + (strobe.selSp ? SP_VEC_OFFSET : '0);

  always_ff @(posedge clk) begin
    if (strobe.loadInit) begin
      vbrOut  <= '0;
      intMask <= MASK_ALL;
      boBit   <= 1'b0;
      csBit   <= 1'b0;
      bankBit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.loadInit && strobe.markPor) fpscrOut <= FPSCR_INIT;
  end

  always_ff @(posedge clk) begin
    if (strobe.capPc) pcOut <= memRdata;
    if (strobe.capSp) spOut <= memRdata;
  end

endmodule

// File: rtl/boot_vec_seq.sv
module boot_vec_seq
  import boot_vec_pkg::*;
#(
  parameter int                ADDR_W        = 32,
  parameter int                DATA_W        = 32,
  parameter int                MASK_W        = 4,
  parameter logic [ADDR_W-1:0] POR_VEC_BASE  = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] MAN_VEC_BASE  = 32'h0000_0008,
  parameter logic [ADDR_W-1:0] SP_VEC_OFFSET = 32'h0000_0004,
  parameter logic [DATA_W-1:0] FPSCR_INIT    = 32'h0004_0001
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              manRst,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] vbrOut,
  output logic [MASK_W-1:0] intMask,
  output logic              boBit,
  output logic              csBit,
  output logic              bankBit,
  output logic [DATA_W-1:0] fpscrOut,
  output logic              runEn
);

  seqStrobe_t strobe;

  boot_vec_ctrl u_ctrl (
    .clk    (clk),
    .porRst (porRst),
    .manRst (manRst),
    .memAck (memAck),
    .strobe (strobe),
    .memReq (memReq),
    .runEn  (runEn)
  );

  boot_vec_dpath #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .MASK_W        (MASK_W),
    .POR_VEC_BASE  (POR_VEC_BASE),
    .MAN_VEC_BASE  (MAN_VEC_BASE),
    .SP_VEC_OFFSET (SP_VEC_OFFSET),
    .FPSCR_INIT    (FPSCR_INIT)
  ) u_dpath (
    .clk      (clk),
    .strobe   (strobe),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .pcOut    (pcOut),
    .spOut    (spOut),
    .vbrOut   (vbrOut),
    .intMask  (intMask),
    .boBit    (boBit),
    .csBit    (csBit),
    .bankBit  (bankBit),
    .fpscrOut (fpscrOut)
  );

endmodule

// File: rtl/boot_vec_chk.sv
module boot_vec_chk (
  input logic        clk,
  input logic        porRst,
  input logic        manRst,
  input logic        memReq,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic [31:0] memRdata,
  input logic [31:0] pcOut,
  input logic [31:0] spOut,
  input logic [31:0] vbrOut,
  input logic [3:0]  intMask,
  input logic        boBit,
  input logic        csBit,
  input logic        bankBit,
  input logic        runEn
);

  logic rstAny;
  logic pcDone;

  assign rstAny = porRst | manRst;

  always_ff @(posedge clk) begin
    if (rstAny)                 pcDone <= 1'b0;
    else if (memReq && memAck)  pcDone <= 1'b1;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rstAny)
    (memReq && !memAck) |=> (memReq && $stable(memAddr))); // R3

  AST_SP_AFTER_PC: assert property (@(posedge clk) disable iff (rstAny)
    (memReq && memAck && !pcDone) |=> (memReq && memAddr == $past(memAddr) + 32'd4)); // R1

  AST_FIRST_REQ_VEC: assert property (@(posedge clk) disable iff (rstAny)
    $rose(memReq) |-> (memAddr == 32'h0 || memAddr == 32'h8)); // R8

  AST_PC_CAPTURE: assert property (@(posedge clk) disable iff (rstAny)
    (memReq && memAck && !pcDone) |=> (pcOut == $past(memRdata))); // R6

  AST_SP_CAPTURE: assert property (@(posedge clk) disable iff (rstAny)
    (memReq && memAck && pcDone) |=> (runEn && spOut == $past(memRdata))); // R7

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rstAny)
    runEn |=> runEn); // R7

  AST_NO_REQ_RUN: assert property (@(posedge clk) disable iff (rstAny)
    runEn |-> !memReq); // R10

  AST_INIT_STATE: assert property (@(posedge clk) disable iff (rstAny)
    runEn |-> (vbrOut == 32'h0 && intMask == 4'hF && !boBit && !csBit && !bankBit)); // R4

endmodule

bind boot_vec_seq boot_vec_chk u_chk (
  .clk      (clk),
  .porRst   (porRst),
  .manRst   (manRst),
  .memReq   (memReq),
  .memAck   (memAck),
  .memAddr  (memAddr),
  .memRdata (memRdata),
  .pcOut    (pcOut),
  .spOut    (spOut),
  .vbrOut   (vbrOut),
  .intMask  (intMask),
  .boBit    (boBit),
  .csBit    (csBit),
  .bankBit  (bankBit),
  .runEn    (runEn)
);

// File: tb/sim_boot_vec_seq.sv
module sim_boot_vec_seq;

  logic        clk = 1'b0;
  logic        porRst = 1'b1;
  logic        manRst = 1'b0;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic [31:0] pcOut, spOut, vbrOut, fpscrOut;
  logic [3:0]  intMask;
  logic        boBit, csBit, bankBit, runEn;

  int          nChecks = 0;
  int          nFails = 0;
  int          nLog;
  int          seed = 0;
  bit          done = 1'b0;
  logic [31:0] addrLog [0:3];

  localparam logic [31:0] FPSCR_EXP = 32'h0004_0001;

  always #4 clk = ~clk;  // 125 MHz

  boot_vec_seq u0 (
    .clk(clk), .porRst(porRst), .manRst(manRst),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memRdata(memRdata),
    .pcOut(pcOut), .spOut(spOut), .vbrOut(vbrOut), .intMask(intMask),
    .boBit(boBit), .csBit(csBit), .bankBit(bankBit), .fpscrOut(fpscrOut),
    .runEn(runEn)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vecData(input logic [31:0] a, input int s);
    return (a * 32'h0101_0101) ^ 32'h5A00_0000 ^ 32'(s * 32'h0001_0003);
  endfunction

  task automatic checkInit(input bit por);
    chk(vbrOut == 32'h0, "R4 vbr", vbrOut, 32'h0);
    chk(intMask == 4'hF, "R4 mask", {28'h0, intMask}, 32'hF);
    chk({boBit, csBit, bankBit} == 3'b000, "R4 flags", {29'h0, boBit, csBit, bankBit}, 32'h0);
    if (por) chk(fpscrOut == FPSCR_EXP, "R5 fpscr cold", fpscrOut, FPSCR_EXP);
  endtask

  // reset, then serve reads with the given latency for up to maxCyc cycles
  task automatic runBoot(input bit por, input bit man, input int lat, input int maxCyc, output bit finished);
    int  cnt;
    bit  spPending;
    nLog = 0;
    seed++;
    memAck = 1'b0;
    @(negedge clk);
    porRst = por;
    manRst = man;
    repeat (2) @(negedge clk);
    chk(memReq == 1'b0, "R10 req in reset", {31'h0, memReq}, 32'h0);
    chk(runEn == 1'b0, "R7 run in reset", {31'h0, runEn}, 32'h0);
    checkInit(por);
    porRst = 1'b0;
    manRst = 1'b0;
    cnt = lat;
    spPending = 1'b0;
    finished = 1'b0;
    for (int c = 0; c < maxCyc && !finished; c++) begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
        cnt = lat;
        if (spPending) begin
          chk(runEn == 1'b1, "R7 rise after sp ack", {31'h0, runEn}, 32'h1);
          finished = 1'b1;
        end
      end else if (memReq) begin
        if (cnt == 0) begin
          chk(runEn == 1'b0, "R7 low while fetching", {31'h0, runEn}, 32'h0);
          if (nLog < 4) addrLog[nLog] = memAddr;
          nLog++;
          memRdata = vecData(memAddr, seed);
          memAck = 1'b1;
          if (nLog == 2) spPending = 1'b1;
        end else begin
          cnt--;
        end
      end
    end
  endtask

  task automatic checkDone(input bit por, input string tag);
    logic [31:0] base;
    base = por ? 32'h0 : 32'h8;
    chk(nLog == 2, {tag, " read count"}, 32'(nLog), 32'd2);
    chk(addrLog[0] == base, {tag, " pc vector"}, addrLog[0], base);
    chk(addrLog[1] == base + 32'h4, {tag, " sp vector"}, addrLog[1], base + 32'h4);
    chk(pcOut == vecData(base, seed), "R6 pc", pcOut, vecData(base, seed));
    chk(spOut == vecData(base + 32'h4, seed), "R6 sp", spOut, vecData(base + 32'h4, seed));
    checkInit(1'b0);
    chk(fpscrOut == FPSCR_EXP, "R5 fpscr kept", fpscrOut, FPSCR_EXP);
    repeat (3) begin
      @(negedge clk);
      chk(runEn == 1'b1, "R7 run sticky", {31'h0, runEn}, 32'h1);
      chk(memReq == 1'b0, "R10 no req running", {31'h0, memReq}, 32'h0);
    end
  endtask

  initial begin
    bit fin;
    repeat (3) @(negedge clk);
    // sweep: latency x reset kind (0 cold, 1 warm, 2 both)
    for (int lat = 0; lat < 4; lat++) begin
      for (int kind = 0; kind < 3; kind++) begin
        runBoot(kind != 1, kind != 0, lat, 100, fin);
        chk(fin, "R3 sequence finished", {31'h0, fin}, 32'h1);
        if (kind == 0) checkDone(1'b1, "R1");
        else if (kind == 1) checkDone(1'b0, "R2");
        else checkDone(1'b1, "R9");
      end
    end
    // long acknowledge delay
    runBoot(1'b0, 1'b1, 40, 200, fin);
    chk(fin, "R3 long wait finished", {31'h0, fin}, 32'h1);
    checkDone(1'b0, "R3");
    // abort while the pc read waits, then warm reset
    runBoot(1'b1, 1'b0, 8, 4, fin);
    chk(nLog == 0, "R8 no ack yet", 32'(nLog), 32'd0);
    runBoot(1'b0, 1'b1, 2, 100, fin);
    checkDone(1'b0, "R8");
    // abort while the sp read waits, then cold reset
    runBoot(1'b1, 1'b0, 5, 10, fin);
    chk(nLog == 1, "R8 one ack", 32'(nLog), 32'd1);
    chk(memReq == 1'b1 && memAddr == 32'h4, "R8 sp pending", memAddr, 32'h4);
    runBoot(1'b1, 1'b0, 1, 100, fin);
    checkDone(1'b1, "R8");
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule